// File: doc/BRIEF.md
# UART Receive Holding Queue with Flow Control

This block holds received characters on the receive side of a UART channel. It sits between the receive shift register and the CPU read port. A completed character from the shift register is represented by a one-cycle `char_done` strobe together with its data byte and three error flags (parity, framing, break). The start of each character is represented by a one-cycle `start_det` strobe. Each character and its flags go into a three-entry queue. The head entry is always visible on the outputs. Only a pulse on `data_rd` advances the queue.

When the queue is full, a newly completed character is parked in the shift register and enters the queue as soon as a slot frees. A further character arriving while one is parked raises a sticky overrun flag on its start strobe and replaces the parked character when it completes. An optional automatic RTS output (active low) is withdrawn when a start strobe arrives while the queue is full. It is asserted again once a slot frees.

The receiver has enable, disable and reset commands. Receiver reset realigns the read and write pointers but never erases the storage, so reading past the valid entries returns stale characters.

Top module: `rx_hold_queue`

## Requirements
- R1: `rd_data`, `head_par`, `head_frm`, `head_brk`, `overrun`, `rx_ready` and `fifo_full` are continuous views. Only a `data_rd` pulse moves the read pointer, so with a full queue and no read or reset the head data holds still.
- R2: The queue holds up to 3 characters in arrival order. `rx_ready` is 1 whenever the count is nonzero. `fifo_full` is 1 when the count is 3. A `data_rd` pulse shows the next entry after the following clock edge.
- R3: Each entry stores its own parity, framing and break flags, and these appear on `head_par`, `head_frm` and `head_brk` while that entry is at the head.
- R4: A character completing while the queue is full is parked. It enters the queue at the first clock edge at which the queue is not full.
- R5: A character completing while one is parked and the queue is still full replaces the parked one, and the queue contents do not change.
- R6: `overrun` rises at the clock edge of a `start_det` that arrives while a character is parked and the queue is full. It does not rise when the character completes.
- R7: `overrun` stays 1 until an `err_reset_cmd` pulse clears it. Receiver reset does not clear it.
- R8: With `auto_rts_en` high, `rts_n` goes to 1 at the edge of a `start_det` seen while the receiver is on and the queue is full. It returns to 0 at the first edge at which the queue is not full. With `auto_rts_en` low, `rts_n` is 0.
- R9: After `rx_disable_cmd`, completed characters are ignored and a character in progress is discarded. After `rx_enable_cmd`, a character is accepted only if its `start_det` comes after the enable.
- R10: `rx_reset_cmd` sets the count to 0 (`rx_ready` 0), discards a parked character, clears the flags of slot 0, and sets both pointers to slot 0. Stored data bytes are kept.
- R11: A `data_rd` pulse with an empty queue still advances the read pointer. The head then shows previously read data, and the pointers stay misaligned until the next receiver reset.
- R12: After `rst`, the receiver is off, `overrun` is 0, `rts_n` is 0 and the queue is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_det | input | 1 | Start bit seen on the line (one-cycle strobe) |
| char_done | input | 1 | Shift register has a complete character (one-cycle strobe) |
| char_data | input | 8 | Data byte of the completed character |
| char_par | input | 1 | Parity error flag of the completed character |
| char_frm | input | 1 | Framing error flag of the completed character |
| char_brk | input | 1 | Break flag of the completed character |
| rx_enable_cmd | input | 1 | Turn the receiver on |
| rx_disable_cmd | input | 1 | Turn the receiver off at once |
| rx_reset_cmd | input | 1 | Receiver reset: realign pointers, empty the queue |
| err_reset_cmd | input | 1 | Clear the sticky overrun flag |
| auto_rts_en | input | 1 | Enable automatic RTS control |
| data_rd | input | 1 | Read the holding data and pop the queue |
| rd_data | output | 8 | Data byte at the read pointer |
| head_par | output | 1 | Parity flag of the head entry |
| head_frm | output | 1 | Framing flag of the head entry |
| head_brk | output | 1 | Break flag of the head entry |
| overrun | output | 1 | Sticky overrun flag |
| rx_ready | output | 1 | Queue holds at least one character |
| fifo_full | output | 1 | Queue holds 3 characters |
| rts_n | output | 1 | Request to send, active low |
| rx_on | output | 1 | Receiver is enabled |

## Verification
The hardest situation to reach is the overrun window: the queue must be full, a character must already be parked, and a further start strobe must arrive before any read. The stimulus fills the queue with three characters and then sends a fourth and a fifth without reading. The following reads then show that the fifth character replaced the fourth. The stale-read case also needs a set-up sequence. It starts from a receiver reset, writes two known bytes, and over-reads until the read pointer wraps, so that the expected stale byte is known in the bench.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

    localparam int DATA_W = 8;

    typedef struct packed {
        logic brk;
        logic frm;
        logic par;
    } rx_flags_t;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        rx_flags_t         flags;
    } rx_char_t;

    localparam rx_flags_t FLAGS_CLEAR = '{brk: 1'b0, frm: 1'b0, par: 1'b0};

endpackage

// File: rtl/rxq_ptrs.sv
module rxq_ptrs #(
    parameter int DEPTH = 3,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             realign,
    input  logic             push,
    input  logic             pop,
    output logic [PTR_W-1:0] wptr,
    output logic [PTR_W-1:0] rptr,
    output logic [CNT_W-1:0] count
);

    function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    logic empty;
    assign empty = (count == '0);

    always_ff @(posedge clk) begin
        if (rst || realign) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (push) wptr <= ptr_inc(wptr);
            // a read always moves the read pointer, even when nothing is valid
            if (pop)  rptr <= ptr_inc(rptr);
            unique case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= empty ? count : count - 1'b1;
                2'b11:   count <= empty ? count + 1'b1 : count;
                default: count <= count;
            endcase
        end
    end

endmodule

// File: rtl/rxq_store.sv
module rxq_store
    import rxq_pkg::*;
#(
    parameter int DEPTH = 3,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [PTR_W-1:0] wr_addr,
    input  rx_char_t         wr_char,
    input  logic             clr_flags,
    input  logic [PTR_W-1:0] clr_addr,
    input  logic [PTR_W-1:0] rd_addr,
    output rx_char_t         rd_char
);

    logic [DATA_W-1:0] data_q  [DEPTH];
    rx_flags_t         flags_q [DEPTH];

    // storage is never cleared; only the flags of one slot can be wiped
    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (wr_en && wr_addr == PTR_W'(i)) begin
                data_q[i]  <= wr_char.data;
                flags_q[i] <= wr_char.flags;
            end else if (clr_flags && clr_addr == PTR_W'(i)) begin
                flags_q[i] <= FLAGS_CLEAR;
            end
        end
    end

    always_comb begin
        rd_char.data  = data_q[rd_addr];
        rd_char.flags = flags_q[rd_addr];
    end

endmodule

// File: rtl/rxq_flow.sv
module rxq_flow (
    input  logic clk,
    input  logic rst,
    input  logic auto_en,
    input  logic start_seen,
    input  logic full,
    output logic rts_n
);

    always_ff @(posedge clk) begin
        if (rst || !auto_en) begin
            rts_n <= 1'b0;
        end else if (start_seen && full) begin
            rts_n <= 1'b1;
        end else if (!full) begin
            rts_n <= 1'b0;
        end
    end

endmodule

// File: rtl/rx_hold_queue.sv
module rx_hold_queue
    import rxq_pkg::*;
#(
    parameter int DEPTH = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_det,
    input  logic              char_done,
    input  logic [DATA_W-1:0] char_data,
    input  logic              char_par,
    input  logic              char_frm,
    input  logic              char_brk,
    input  logic              rx_enable_cmd,
    input  logic              rx_disable_cmd,
    input  logic              rx_reset_cmd,
    input  logic              err_reset_cmd,
    input  logic              auto_rts_en,
    input  logic              data_rd,
    output logic [DATA_W-1:0] rd_data,
    output logic              head_par,
    output logic              head_frm,
    output logic              head_brk,
    output logic              overrun,
    output logic              rx_ready,
    output logic              fifo_full,
    output logic              rts_n,
    output logic              rx_on
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [PTR_W-1:0] wptr, rptr;
    logic [CNT_W-1:0] count;
    logic             enabled, armed, parked;
    rx_char_t         hold_q, incoming, wr_char, head;
    logic             full, take, direct, drain, push, pop;

    assign full = (count == CNT_W'(DEPTH));

    always_comb begin
        incoming.data      = char_data;
        incoming.flags.par = char_par;
        incoming.flags.frm = char_frm;
        incoming.flags.brk = char_brk;
    end

    // a completed character counts only if its start bit was seen while on
    assign take   = char_done && armed && enabled && !rx_disable_cmd && !rx_reset_cmd;
    assign direct = take && !parked && !full;
    assign drain  = parked && !full && !rx_reset_cmd;
    assign push   = drain || direct;
    assign wr_char = drain ? hold_q : incoming;
    assign pop    = data_rd && !rx_reset_cmd;

    always_ff @(posedge clk) begin
        if (rst) begin
            enabled <= 1'b0;
            armed   <= 1'b0;
            parked  <= 1'b0;
            overrun <= 1'b0;
            hold_q  <= '0;
        end else begin
            if (rx_disable_cmd)     enabled <= 1'b0;
            else if (rx_enable_cmd) enabled <= 1'b1;

            if (rx_reset_cmd || rx_disable_cmd || !enabled) armed <= 1'b0;
            else if (start_det)                             armed <= 1'b1;
            else if (take)                                  armed <= 1'b0;

            if (rx_reset_cmd) begin
                parked <= 1'b0;
            end else if (take && !direct) begin
                // waits in the shift register; an older parked one is lost
                parked <= 1'b1;
                hold_q <= incoming;
            end else if (drain) begin
                parked <= 1'b0;
            end

            if (err_reset_cmd)
                overrun <= 1'b0;
            else if (start_det && enabled && parked && full)
                overrun <= 1'b1;
        end
    end

    rxq_ptrs #(.DEPTH(DEPTH)) u_ptrs (
        .clk     (clk),
        .rst     (rst),
        .realign (rx_reset_cmd),
        .push    (push),
        .pop     (pop),
        .wptr    (wptr),
        .rptr    (rptr),
        .count   (count)
    );

    rxq_store #(.DEPTH(DEPTH)) u_store (
        .clk       (clk),
        .wr_en     (push),
        .wr_addr   (wptr),
        .wr_char   (wr_char),
        .clr_flags (rx_reset_cmd),
        .clr_addr  ('0),
        .rd_addr   (rptr),
        .rd_char   (head)
    );

    rxq_flow u_flow (
        .clk        (clk),
        .rst        (rst),
        .auto_en    (auto_rts_en),
        .start_seen (start_det && enabled),
        .full       (full),
        .rts_n      (rts_n)
    );

    assign rd_data   = head.data;
    assign head_par  = head.flags.par;
    assign head_frm  = head.flags.frm;
    assign head_brk  = head.flags.brk;
    assign rx_ready  = (count != '0);
    assign fifo_full = full;
    assign rx_on     = enabled;

endmodule

// File: rtl/rx_hold_queue_checker.sv
module rx_hold_queue_checker (
    input logic       clk,
    input logic       rst,
    input logic       start_det,
    input logic       data_rd,
    input logic       rx_reset_cmd,
    input logic       err_reset_cmd,
    input logic       auto_rts_en,
    input logic [7:0] rd_data,
    input logic       overrun,
    input logic       rx_ready,
    input logic       fifo_full,
    input logic       rts_n
);

    assert_head_stable_R1: assert property (@(posedge clk) disable iff (rst)
        (fifo_full && !data_rd && !rx_reset_cmd) |=> $stable(rd_data));

    assert_full_is_ready_R2: assert property (@(posedge clk) disable iff (rst)
        fifo_full |-> rx_ready);

    assert_overrun_on_start_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(overrun) |-> $past(start_det));

    assert_overrun_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        (overrun && !err_reset_cmd) |=> overrun);

    assert_rts_drop_cause_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(rts_n) |-> $past(start_det && fifo_full && auto_rts_en));

    assert_rts_idle_off_R8: assert property (@(posedge clk) disable iff (rst)
        !auto_rts_en |=> !rts_n);

    assert_reset_empties_R10: assert property (@(posedge clk) disable iff (rst)
        rx_reset_cmd |=> !rx_ready);

endmodule

bind rx_hold_queue rx_hold_queue_checker u_checker (
    .clk           (clk),
    .rst           (rst),
    .start_det     (start_det),
    .data_rd       (data_rd),
    .rx_reset_cmd  (rx_reset_cmd),
    .err_reset_cmd (err_reset_cmd),
    .auto_rts_en   (auto_rts_en),
    .rd_data       (rd_data),
    .overrun       (overrun),
    .rx_ready      (rx_ready),
    .fifo_full     (fifo_full),
    .rts_n         (rts_n)
);

// File: tb/rx_hold_queue_test.sv
module rx_hold_queue_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start_det = 0, char_done = 0;
    logic [7:0] char_data = 0;
    logic       char_par = 0, char_frm = 0, char_brk = 0;
    logic       rx_enable_cmd = 0, rx_disable_cmd = 0, rx_reset_cmd = 0, err_reset_cmd = 0;
    logic       auto_rts_en = 0, data_rd = 0;
    logic [7:0] rd_data;
    logic       head_par, head_frm, head_brk, overrun, rx_ready, fifo_full, rts_n, rx_on;

    int tests = 0, fails = 0, cycles = 0;

    always #5 clk = ~clk;

    rx_hold_queue uut (.*);

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            fails++;
            $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cycles);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic send(input logic [7:0] d, input logic [2:0] f);
        tick(); start_det = 1;
        tick(); start_det = 0; char_done = 1; char_data = d;
        {char_brk, char_frm, char_par} = f;
        tick(); char_done = 0;
    endtask

    task automatic rd();
        tick(); data_rd = 1;
        tick(); data_rd = 0;
    endtask

    task automatic pulse(ref logic s);
        tick(); s = 1;
        tick(); s = 0;
    endtask

    initial begin
        repeat (3) tick();
        rst = 0;
        tick();
        // R12 reset state
        chk("R12 rx_ready", rx_ready, 0);
        chk("R12 overrun", overrun, 0);
        chk("R12 rts_n", rts_n, 0);
        chk("R12 rx_on", rx_on, 0);

        pulse(rx_enable_cmd);
        pulse(rx_reset_cmd);

        // R2 R3: flag and data sweep through a single entry
        for (int p = 0; p < 8; p++) begin
            logic [7:0] d;
            d = 8'(p * 37 + 11);
            send(d, 3'(p));
            chk("R2 ready", rx_ready, 1);
            chk("R2 data", rd_data, d);
            chk("R3 flags", {head_brk, head_frm, head_par}, p);
            rd();
            chk("R2 empty", rx_ready, 0);
        end

        // R2: fill to each level and drain in order
        for (int n = 1; n <= 3; n++) begin
            for (int k = 0; k < n; k++) send(8'(16 * n + k), 3'(k));
            chk("R2 full", fifo_full, (n == 3) ? 1 : 0);
            for (int k = 0; k < n; k++) begin
                chk("R2 order", rd_data, 16 * n + k);
                chk("R3 order flags", {head_brk, head_frm, head_par}, k);
                rd();
            end
            chk("R2 drained", rx_ready, 0);
        end

        // R4 R5 R6 R7 R8: overrun and automatic RTS
        auto_rts_en = 1;
        pulse(rx_reset_cmd);
        send(8'hA1, 0); send(8'hA2, 0); send(8'hA3, 0);
        chk("R2 full", fifo_full, 1);
        chk("R8 rts before", rts_n, 0);
        send(8'hA4, 3'b001);
        chk("R8 rts dropped", rts_n, 1);
        chk("R6 no overrun yet", overrun, 0);
        chk("R4 still full", fifo_full, 1);
        chk("R1 head unchanged", rd_data, 8'hA1);
        tick(); start_det = 1;
        tick(); start_det = 0;
        chk("R6 overrun at start", overrun, 1);
        char_done = 1; char_data = 8'hA5; {char_brk, char_frm, char_par} = 3'b010;
        tick(); char_done = 0;
        chk("R5 head unchanged", rd_data, 8'hA1);
        rd();
        tick();
        chk("R4 parked moved in", fifo_full, 1);
        chk("R8 rts back", rts_n, 0);
        chk("R5 next", rd_data, 8'hA2); rd();
        chk("R5 next", rd_data, 8'hA3); rd();
        chk("R5 replaced", rd_data, 8'hA5);
        chk("R5 replaced flags", {head_brk, head_frm, head_par}, 3'b010);
        rd();
        chk("R5 drained", rx_ready, 0);
        pulse(rx_reset_cmd);
        chk("R7 survives rx reset", overrun, 1);
        pulse(err_reset_cmd);
        chk("R7 cleared", overrun, 0);

        // R8 with auto off
        auto_rts_en = 0;
        send(8'h01, 0); send(8'h02, 0); send(8'h03, 0); send(8'h04, 0);
        chk("R8 off", rts_n, 0);
        pulse(rx_reset_cmd);

        // R9: disable and re-enable
        pulse(rx_disable_cmd);
        send(8'h55, 0);
        chk("R9 ignored when off", rx_ready, 0);
        pulse(rx_enable_cmd);
        tick(); start_det = 1;
        tick(); start_det = 0;
        pulse(rx_disable_cmd);
        pulse(rx_enable_cmd);
        pulse(char_done);
        chk("R9 partial dropped", rx_ready, 0);
        send(8'h66, 0);
        chk("R9 accepted", rd_data, 8'h66);
        chk("R9 ready", rx_ready, 1);

        // R10 R11: stale reads and realignment
        pulse(rx_reset_cmd);
        chk("R10 empty", rx_ready, 0);
        send(8'hC1, 3'b111); send(8'hC2, 0);
        rd(); rd(); rd();
        chk("R11 empty", rx_ready, 0);
        chk("R11 stale", rd_data, 8'hC1);
        send(8'hC3, 0);
        chk("R11 misaligned", rd_data, 8'hC1);
        chk("R11 flags", {head_brk, head_frm, head_par}, 3'b111);
        pulse(rx_reset_cmd);
        chk("R10 ready", rx_ready, 0);
        chk("R10 data kept", rd_data, 8'hC1);
        chk("R10 flags cleared", {head_brk, head_frm, head_par}, 0);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule